// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

A purely combinational unit that manipulates bit fields inside data words. A 3-bit operation code selects the operation. A 5-bit position and a 5-bit width describe the field. The unit computes one of five operations:

- a sign-extending field extract;
- a zero-extending field extract;
- a deposit of a field from a second operand into a first operand;
- generation of a shifted-data/mask pair;
- a two-word funnel extract that takes a window out of the concatenation of both operands.

The primary result appears on `res_o`. A second word, `mask_o`, carries the field mask that only the mask-generation operation produces.

Three operations are defined only when the field fits inside the word: signed extract, insert and mask generation. If such an operation is requested with position plus width above 31, the unit drops `valid_o` and drives zeros. The surrounding datapath then keeps its destination unchanged. Instruction decode, register write-back and status flags belong to the caller.

The data width is a parameter; the default is 32. The funnel extract can be built in either of two circuit forms, selected by a parameter.

Top module: `bfx_unit`

## Requirements
- R1: Signed extract (op 0), when pos+width ≤ 31 and width > 0, returns bits [pos+width-1:pos] of `a_i` in the low bits, with bit pos+width-1 copied into all upper bits, and `valid_o`=1.
- R2: Signed extract with width 0 returns 0 with `valid_o`=1.
- R3: Unsigned extract (op 1) returns (`a_i` >> pos) with all bits at and above index width cleared. It has no range guard, so `valid_o`=1 for every pos and width.
- R4: Unsigned extract with width 0 returns 0.
- R5: Insert (op 2), when pos+width ≤ 31, returns `a_i` with bits [pos+width-1:pos] replaced by the low width bits of `b_i`, and `valid_o`=1.
- R6: Mask generation (op 3), when pos+width ≤ 31, returns `b_i` << pos on `res_o`, ((1<<width)-1)<<pos on `mask_o`, and `valid_o`=1.
- R7: Funnel extract (op 4) returns (`b_i` << pos) | (`a_i` >> (32-pos)) for pos ≥ 1 and any width, with `valid_o`=1.
- R8: Funnel extract with pos 0 returns `b_i` unchanged. With `a_i` equal to `b_i`, it returns `b_i` rotated left by pos.
- R9: Ops 0, 2 and 3 with pos+width > 31 drive `valid_o`=0, `res_o`=0 and `mask_o`=0.
- R10: `mask_o` is 0 for every op other than mask generation.
- R11: Op codes 5, 6 and 7 drive `valid_o`=0, `res_o`=0 and `mask_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation: 0 signed extract, 1 unsigned extract, 2 insert, 3 mask generation, 4 funnel extract |
| pos_i | input | 5 | Field start bit, or funnel shift amount |
| width_i | input | 5 | Field length in bits |
| a_i | input | 32 | First operand (extract source, insert base, funnel low word) |
| b_i | input | 32 | Second operand (inserted field, mask data, funnel high word) |
| res_o | output | 32 | Primary result |
| mask_o | output | 32 | Field mask from mask generation, otherwise 0 |
| valid_o | output | 1 | Low when the requested operation is undefined for these inputs |

## Verification
Every op code, including the undefined ones, is swept over all 1024 position/width pairs with three operand patterns. The first is an irregular pair. It exposes off-by-one errors in the field edges and in the shift amounts. The second puts all ones in `a_i` and zero in `b_i`. This shows whether unused bits leak through, and whether a sign bit fills exactly the upper bits. The third uses equal operands. It shows whether the funnel extract degenerates to a rotate. Together with the exhaustive pos/width grid, these patterns separate the in-range cases from the guard boundary at pos+width = 31 versus 32.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   localparam logic [2:0] BF_SEXT   = 3'd0;
   localparam logic [2:0] BF_UEXT   = 3'd1;
   localparam logic [2:0] BF_INS    = 3'd2;
   localparam logic [2:0] BF_MASK   = 3'd3;
   localparam logic [2:0] BF_FUNNEL = 3'd4;
endpackage

// File: rtl/bfx_low_mask.sv
// Thermometer mask: bit g is set when g < width.
module bfx_low_mask #(
   parameter int DW = 32,
   localparam int PW = $clog2(DW)
) (
   input  logic [PW-1:0] width_i,
   output logic [DW-1:0] mask_o
);
   for (genvar g = 0; g < DW; g++) begin : g_bit
      assign mask_o[g] = (width_i > PW'(g));
   end
endmodule

// File: rtl/bfx_extract.sv
// Field extract; SIGNED selects sign or zero fill above the field.
module bfx_extract #(
   parameter int DW     = 32,
   parameter bit SIGNED = 1'b0,
   localparam int PW = $clog2(DW)
) (
   input  logic [DW-1:0] a_i,
   input  logic [PW-1:0] pos_i,
   input  logic [PW-1:0] width_i,
   input  logic [DW-1:0] low_mask_i,
   output logic [DW-1:0] res_o
);
   logic [DW-1:0] shifted;
   logic [DW-1:0] field;

   assign shifted = a_i >> pos_i;
   assign field   = shifted & low_mask_i;

   if (SIGNED) begin : g_sign
      logic [PW-1:0] top_idx;
      logic          sign_bit;
      assign top_idx  = width_i - PW'(1);
      assign sign_bit = (width_i != '0) && shifted[top_idx];
      assign res_o    = field | ({DW{sign_bit}} & ~low_mask_i);
   end else begin : g_zero
      assign res_o = field;
   end
endmodule

// File: rtl/bfx_deposit.sv
// Builds the placed field mask, the shifted data and the deposit result.
module bfx_deposit #(
   parameter int DW = 32,
   localparam int PW = $clog2(DW)
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic [PW-1:0] pos_i,
   input  logic [DW-1:0] low_mask_i,
   output logic [DW-1:0] placed_mask_o,
   output logic [DW-1:0] placed_data_o,
   output logic [DW-1:0] merged_o
);
   assign placed_mask_o = low_mask_i << pos_i;
   assign placed_data_o = b_i << pos_i;
   assign merged_o      = (a_i & ~placed_mask_o) | (placed_data_o & placed_mask_o);
endmodule

// File: rtl/bfx_funnel.sv
// Upper word of {b,a} shifted left by pos. WIDE_SHIFT picks one double-width
// shifter; otherwise two single-width shifters with an explicit pos==0 bypass.
module bfx_funnel #(
   parameter int DW         = 32,
   parameter bit WIDE_SHIFT = 1'b1,
   localparam int PW = $clog2(DW)
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic [PW-1:0] pos_i,
   output logic [DW-1:0] res_o
);
   if (WIDE_SHIFT) begin : g_wide
      logic [2*DW-1:0] joined;
      assign joined = {b_i, a_i} << pos_i;
      assign res_o  = joined[2*DW-1:DW];
   end else begin : g_split
      logic [PW:0] back_amt;
      assign back_amt = (PW+1)'(DW) - {1'b0, pos_i};
      assign res_o    = (pos_i == '0) ? b_i : ((b_i << pos_i) | (a_i >> back_amt));
   end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
   parameter int DW          = 32,
   parameter bit FUNNEL_WIDE = 1'b1,
   localparam int PW = $clog2(DW)
) (
   input  logic [2:0]    op_i,
   input  logic [PW-1:0] pos_i,
   input  logic [PW-1:0] width_i,
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] res_o,
   output logic [DW-1:0] mask_o,
   output logic          valid_o
);
   import bfx_pkg::*;

   if (DW < 8 || (1 << PW) != DW) begin : g_bad_width
      $error("bfx_unit: DW must be a power of two of at least 8");
   end

   logic [DW-1:0] low_mask;
   logic [DW-1:0] sext_res;
   logic [DW-1:0] uext_res;
   logic [DW-1:0] placed_mask;
   logic [DW-1:0] placed_data;
   logic [DW-1:0] merged;
   logic [DW-1:0] funnel_res;
   logic [PW:0]   field_end;
   logic          fits;

   assign field_end = {1'b0, pos_i} + {1'b0, width_i};
   assign fits      = (field_end <= (PW+1)'(DW - 1));

   bfx_low_mask #(.DW(DW)) i_low_mask (
      .width_i (width_i),
      .mask_o  (low_mask)
   );

   bfx_extract #(.DW(DW), .SIGNED(1'b1)) i_sext (
      .a_i        (a_i),
      .pos_i      (pos_i),
      .width_i    (width_i),
      .low_mask_i (low_mask),
      .res_o      (sext_res)
   );

   bfx_extract #(.DW(DW), .SIGNED(1'b0)) i_uext (
      .a_i        (a_i),
      .pos_i      (pos_i),
      .width_i    (width_i),
      .low_mask_i (low_mask),
      .res_o      (uext_res)
   );

   bfx_deposit #(.DW(DW)) i_deposit (
      .a_i           (a_i),
      .b_i           (b_i),
      .pos_i         (pos_i),
      .low_mask_i    (low_mask),
      .placed_mask_o (placed_mask),
      .placed_data_o (placed_data),
      .merged_o      (merged)
   );

   bfx_funnel #(.DW(DW), .WIDE_SHIFT(FUNNEL_WIDE)) i_funnel (
      .a_i   (a_i),
      .b_i   (b_i),
      .pos_i (pos_i),
      .res_o (funnel_res)
   );

   always_comb begin
      res_o   = '0;
      mask_o  = '0;
      valid_o = 1'b0;
      case (op_i)
         BF_SEXT: begin
            valid_o = fits;
            if (fits) res_o = sext_res;
         end
         BF_UEXT: begin
            valid_o = 1'b1;
            res_o   = uext_res;
         end
         BF_INS: begin
            valid_o = fits;
            if (fits) res_o = merged;
         end
         BF_MASK: begin
            valid_o = fits;
            if (fits) begin
               res_o  = placed_data;
               mask_o = placed_mask;
            end
         end
         BF_FUNNEL: begin
            valid_o = 1'b1;
            res_o   = funnel_res;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
   parameter int DW = 32,
   localparam int PW = $clog2(DW)
) (
   input logic [2:0]    op_i,
   input logic [PW-1:0] pos_i,
   input logic [PW-1:0] width_i,
   input logic [DW-1:0] a_i,
   input logic [DW-1:0] b_i,
   input logic [DW-1:0] res_o,
   input logic [DW-1:0] mask_o,
   input logic          valid_o
);
   int span;
   assign span = int'(pos_i) + int'(width_i);

   always_comb begin
      if (op_i == 3'd1 && width_i == '0)
         a_r4_uext_zero_width: assert (res_o == '0 && valid_o);
      if (op_i == 3'd0 && width_i == '0)
         a_r2_sext_zero_width: assert (res_o == '0 && valid_o);
      if (op_i == 3'd0 && valid_o && width_i != '0)
         a_r1_sext_upper_fill: assert (((res_o >> (width_i - PW'(1))) == '0) ||
                                       (($signed(res_o) >>> (width_i - PW'(1))) == -1));
      if (op_i == 3'd4 && pos_i == '0)
         a_r8_funnel_pass: assert (res_o == b_i);
      if (op_i == 3'd3 && valid_o)
         a_r6_mask_count: assert ($countones(mask_o) == int'(width_i));
      if (op_i == 3'd2 && valid_o)
         a_r5_insert_keeps_low: assert (((res_o ^ a_i) & ((DW'(1) << pos_i) - DW'(1))) == '0);
      if ((op_i == 3'd0 || op_i == 3'd2 || op_i == 3'd3) && span > DW - 1)
         a_r9_guard: assert (!valid_o && res_o == '0 && mask_o == '0);
      if (op_i != 3'd3)
         a_r10_mask_idle: assert (mask_o == '0);
      if (op_i > 3'd4)
         a_r11_undefined_op: assert (!valid_o && res_o == '0);
   end
endmodule

bind bfx_unit bfx_unit_chk #(.DW(DW)) i_bfx_unit_chk (
   .op_i    (op_i),
   .pos_i   (pos_i),
   .width_i (width_i),
   .a_i     (a_i),
   .b_i     (b_i),
   .res_o   (res_o),
   .mask_o  (mask_o),
   .valid_o (valid_o)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
   logic        clk = 1'b0;
   logic [2:0]  op;
   logic [4:0]  pos;
   logic [4:0]  width;
   logic [31:0] a;
   logic [31:0] b;
   logic [31:0] res;
   logic [31:0] mask;
   logic        valid;
   int          n_vec  = 0;
   int          n_fail = 0;
   int          cycles = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   bfx_unit i_bfx_unit (
      .op_i    (op),
      .pos_i   (pos),
      .width_i (width),
      .a_i     (a),
      .b_i     (b),
      .res_o   (res),
      .mask_o  (mask),
      .valid_o (valid)
   );

   function automatic string req_tag(input int o, input int p, input int w, input bit same);
      bit ok = (p + w) <= 31;
      case (o)
         0: return !ok ? "R9" : (w == 0 ? "R2" : "R1");
         1: return w == 0 ? "R4" : "R3";
         2: return ok ? "R5" : "R9";
         3: return ok ? "R6" : "R9";
         4: return (p == 0 || same) ? "R8" : "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(input int o, input int p, input int w,
                        input logic [31:0] va, input logic [31:0] vb);
      logic [63:0] m64;
      logic [31:0] e_res, e_mask;
      logic        e_val;
      bit          ok;
      string       tag;
      @(negedge clk);
      op = 3'(o); pos = 5'(p); width = 5'(w); a = va; b = vb;
      #1;
      ok     = (p + w) <= 31;
      m64    = ((64'd1 << w) - 64'd1) << p;
      e_res  = '0; e_mask = '0; e_val = 1'b0;
      case (o)
         0: if (ok) begin
               e_val = 1'b1;
               if (w != 0) e_res = 32'($signed(va << (32 - p - w)) >>> (32 - w));
            end
         1: begin
               e_val = 1'b1;
               if (w != 0) e_res = (va >> p) & (32'hFFFF_FFFF >> (32 - w));
            end
         2: if (ok) begin
               e_val = 1'b1;
               e_res = (va & ~m64[31:0]) | ((vb << p) & m64[31:0]);
            end
         3: if (ok) begin
               e_val = 1'b1; e_res = vb << p; e_mask = m64[31:0];
            end
         4: begin
               e_val = 1'b1;
               e_res = (p == 0) ? vb : ((vb << p) | (va >> (32 - p)));
            end
         default: ;
      endcase
      n_vec++;
      if (res !== e_res || mask !== e_mask || valid !== e_val) begin
         n_fail++;
         tag = (mask !== e_mask && o != 3) ? "R10" : req_tag(o, p, w, va == vb);
         $display("FAIL %s op=%0d pos=%0d width=%0d: res=%h mask=%h valid=%b expected res=%h mask=%h valid=%b",
                  tag, o, p, w, res, mask, valid, e_res, e_mask, e_val);
      end
   endtask

   initial begin
      op = '0; pos = '0; width = '0; a = '0; b = '0;
      // Idle-input state: signed extract of zero width gives 0, valid (R2)
      apply(0, 0, 0, 32'h0, 32'h0);
      for (int pat = 0; pat < 3; pat++) begin
         logic [31:0] va, vb;
         case (pat)
            0: begin va = 32'h8F3C_6A51; vb = 32'h71E2_9BD4; end
            1: begin va = 32'hFFFF_FFFF; vb = 32'h0000_0000; end
            default: begin va = 32'hC35A_0F96; vb = 32'hC35A_0F96; end
         endcase
         for (int o = 0; o < 8; o++)
            for (int p = 0; p < 32; p++)
               for (int w = 0; w < 32; w++)
                  apply(o, p, w, va, vb);
      end
      done = 1'b1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (done) begin
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end else if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got %0d vectors expected 24577", n_vec);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule